// File: doc/BRIEF.md
# Lock-Qualified Reset Release Synchronizer

This block turns an asynchronous, active-high reset request into a reset that is safe to fan out to clocked logic. The output reset goes active the moment the request appears, with no clock needed. It goes inactive only on a rising clock edge, and only after a short register chain has seen a run of clean cycles. Every flop it drives therefore leaves reset on the same cycle. Static timing can also check the release path against the flops' recovery time, because the output comes straight from a register.

A second input reports whether the clock source is locked. While that input is low, the block behaves as if the reset request were present. When lock is lost during operation, the output reasserts at once, and the full release sequence runs again once lock returns.

The chain is held in reset-active form. Every stage presets to 1, and a 0 is shifted in from the front on each rising edge while neither clearing condition is present. The output is the last stage itself, which equals the inverse of a chain that clears to zeros and fills with ones. The design has no enumerated state. Its phases are HELD (any clearing condition present, all stages 1), FILLING (clearing gone, zeros moving through the chain) and RUN (last stage 0). Its transitions are HELD to FILLING when the clearing condition drops, FILLING to RUN on the edge where the zero reaches the last stage, and any phase to HELD, without a clock, when a clearing condition appears.

Top module: `rst_release_sync`

## Requirements
- R1: While `arst_req` is 1, `rst_out` is 1, and it rises as soon as `arst_req` rises, with no clock edge in between.
- R2: While `clk_locked` is 0, `rst_out` is 1, and it rises as soon as `clk_locked` falls, with no clock edge in between.
- R3: Once both `arst_req` is 0 and `clk_locked` is 1, `rst_out` stays 1 through the first STAGES-1 rising edges and falls at the STAGES-th rising edge (the 2nd edge for the default STAGES = 2).
- R4: `rst_out` only ever falls shortly after a rising edge of `clk`, never between edges.
- R5: If `clk_locked` drops while `rst_out` is 0, `rst_out` reasserts at once, and after lock returns the full STAGES-edge release sequence repeats.
- R6: An `arst_req` pulse that starts and ends between two clock edges still forces `rst_out` to 1 and restarts the full STAGES-edge release sequence.
- R7: The chain length is set by the parameter STAGES (at least 2). With STAGES = 4, `rst_out` falls at the 4th rising edge after release.
- R8: The chain always fills from the front: a stage that is released (0) never follows a stage that is still held (1) further back in the chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the release |
| arst_req | input | 1 | Asynchronous reset request, active high |
| clk_locked | input | 1 | Clock source lock indication, 1 when locked |
| rst_out | output | 1 | Synchronized reset, active high, registered |

## Verification
The bench pulses the reset request and the lock input between clock edges. It confirms that the output rises before any edge arrives. A design that waited for the clock to assert would fail this check. It counts the edges after release and expects the fall on exactly the STAGES-th edge, at both default and extended chain lengths, so an off-by-one chain or a release that skips the chain would show up. It also drops lock during normal operation and uses reset pulses shorter than a clock period. A design that ignored lock, or that let a short pulse slip past without restarting the whole sequence, would release too early.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    // Default chain length; two stages is the minimum that lets a
    // metastable first stage settle before the output moves.
    localparam int RRS_STAGES_DEF = 2;
    localparam int RRS_STAGES_MIN = 2;

    // Phases of the release sequence, used for naming only.
    typedef enum logic [1:0] {
        PH_HELD    = 2'd0,
        PH_FILLING = 2'd1,
        PH_RUN     = 2'd2
    } rrs_phase_e;
endpackage

// File: rtl/rrs_clear_src.sv
module rrs_clear_src (
    input  logic arst_req,
    input  logic clk_locked,
    output logic clear
);
    // Any reason to hold the design in reset clears the chain at once.
    always_comb begin
        clear = arst_req | ~clk_locked;
    end
endmodule

// File: rtl/rrs_chain.sv
module rrs_chain #(
    parameter int STAGES = rrs_pkg::RRS_STAGES_DEF
) (
    input  logic clk,
    input  logic clear,
    output logic hold
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] stg;

    // Stage 0 takes a released value; each later stage copies its neighbour.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or posedge clear) begin
                if (clear) stg[0] <= 1'b1;
                else       stg[0] <= 1'b0;
            end
        end else begin : g_body
            always_ff @(posedge clk or posedge clear) begin
                if (clear) stg[i] <= 1'b1;
                else       stg[i] <= stg[i-1];
            end
        end
    end

    assign hold = stg[LAST];

    // R3
    first_edge_hold_chk: assert property (@(posedge clk)
        $past(clear) |-> hold);

    // R4
    release_order_chk: assert property (@(posedge clk) disable iff (clear)
        $fell(hold) |-> $past(stg[LAST-1] == 1'b0));

    // R8
    fill_front_chk: assert property (@(posedge clk) disable iff (clear)
        (({stg[LAST-1:0], 1'b0} & ~stg) == '0));
endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
    parameter int STAGES = rrs_pkg::RRS_STAGES_DEF
) (
    input  logic clk,
    input  logic arst_req,
    input  logic clk_locked,
    output logic rst_out
);
    // R7: STAGES below the minimum is rejected at elaboration.
    if (STAGES < rrs_pkg::RRS_STAGES_MIN) begin : g_bad_len
        initial $error("rst_release_sync: STAGES must be at least 2");
    end

    logic clear;

    rrs_clear_src u_clear (
        .arst_req   (arst_req),
        .clk_locked (clk_locked),
        .clear      (clear)
    );

    rrs_chain #(.STAGES(STAGES)) u_chain (
        .clk   (clk),
        .clear (clear),
        .hold  (rst_out)
    );

    // R1
    req_forces_rst_chk: assert property (@(posedge clk)
        arst_req |-> rst_out);

    // R2
    unlock_forces_rst_chk: assert property (@(posedge clk)
        !clk_locked |-> rst_out);
endmodule

// File: tb/rst_release_sync_bench.sv
`timescale 1ns/1ps
module rst_release_sync_bench;
    logic clk = 1'b0;
    logic arst_req = 1'b1;
    logic clk_locked = 1'b0;
    logic rst_out;
    logic rst_out4;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    realtime last_pos = 0.0;

    always #2.5 clk = ~clk;
    always @(posedge clk) last_pos = $realtime;

    rst_release_sync u_rst_release_sync (
        .clk(clk), .arst_req(arst_req), .clk_locked(clk_locked), .rst_out(rst_out));

    rst_release_sync #(.STAGES(4)) u_rst_release_sync_d4 (
        .clk(clk), .arst_req(arst_req), .clk_locked(clk_locked), .rst_out(rst_out4));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // R4: every fall of the output sits right after a rising edge.
    always @(negedge rst_out) begin
        if ($realtime > 0.0)
            check(($realtime - last_pos) < 0.5, "R4", int'(($realtime - last_pos) * 1000.0), 0);
    end

    // Move to just after the next rising edge.
    task automatic after_edge();
        @(posedge clk);
        #1;
    endtask

    // Release both conditions mid-cycle and verify the edge count for both widths.
    task automatic release_and_count(input string req);
        @(negedge clk);
        arst_req = 1'b0;
        clk_locked = 1'b1;
        for (int e = 1; e <= 4; e++) begin
            after_edge();
            check(rst_out == (e < 2 ? 1'b1 : 1'b0), req, rst_out, (e < 2) ? 1 : 0);
            check(rst_out4 == (e < 4 ? 1'b1 : 1'b0), "R7", rst_out4, (e < 4) ? 1 : 0);
        end
    endtask

    task automatic t_reset_state();
        #1;
        check(rst_out == 1'b1, "R1", rst_out, 1);
        check(rst_out4 == 1'b1, "R1", rst_out4, 1);
        after_edge();
        after_edge();
        check(rst_out == 1'b1, "R2", rst_out, 1);
        arst_req = 1'b0;
        after_edge();
        after_edge();
        check(rst_out == 1'b1, "R2", rst_out, 1);
    endtask

    task automatic t_async_req();
        @(negedge clk);
        #0.5;
        arst_req = 1'b1;
        #0.5;
        check(rst_out == 1'b1, "R1", rst_out, 1);
        check(rst_out4 == 1'b1, "R1", rst_out4, 1);
        release_and_count("R3");
    endtask

    task automatic t_lock_drop();
        @(negedge clk);
        #0.5;
        clk_locked = 1'b0;
        #0.5;
        check(rst_out == 1'b1, "R2", rst_out, 1);
        after_edge();
        check(rst_out == 1'b1, "R5", rst_out, 1);
        @(negedge clk);
        clk_locked = 1'b1;
        after_edge();
        check(rst_out == 1'b1, "R5", rst_out, 1);
        after_edge();
        check(rst_out == 1'b0, "R5", rst_out, 0);
        after_edge();
        after_edge();
        check(rst_out4 == 1'b0, "R7", rst_out4, 0);
    endtask

    task automatic t_short_pulse();
        @(negedge clk);
        #0.3;
        arst_req = 1'b1;
        #0.4;
        check(rst_out == 1'b1, "R6", rst_out, 1);
        arst_req = 1'b0;
        #0.4;
        check(rst_out == 1'b1, "R6", rst_out, 1);
        after_edge();
        check(rst_out == 1'b1, "R6", rst_out, 1);
        after_edge();
        check(rst_out == 1'b0, "R6", rst_out, 0);
    endtask

    task automatic t_relock_mid_fill();
        // Lock lost while the chain is filling: sequence starts over.
        @(negedge clk);
        clk_locked = 1'b0;
        @(negedge clk);
        clk_locked = 1'b1;
        after_edge();
        @(negedge clk);
        clk_locked = 1'b0;
        #0.5;
        check(rst_out == 1'b1, "R5", rst_out, 1);
        release_and_count("R5");
    endtask

    initial begin
        t_reset_state();
        release_and_count("R3");
        t_async_req();
        t_lock_drop();
        t_short_pulse();
        t_relock_mid_fill();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule